// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the combinational arithmetic and logic stage of a load/store processor datapath. It receives a first operand straight from the register file and a second operand that has already been shifted or built from an immediate, together with a 4-bit operation code. In the same cycle it produces a 32-bit result, a strobe that says whether the result should be written back, and a fresh set of negative, zero, carry and overflow flags.

It covers four bitwise operations (including a bit-clear that masks the first operand with the inverse of the second), addition and subtraction, and four flag-only operations. The flag-only operations run the adder or the bitwise path exactly like their writing counterparts, but they suppress the write strobe. The carry produced by the upstream shifter enters on its own pin and becomes the carry flag for bitwise operations. The current flags also enter on their own pin, so that a flag left unchanged is simply passed through. Codes that name no operation leave everything untouched.

Top module: `alu_dp`

## Requirements
- R1: Opcode 0x0 gives A AND B, 0xC gives A OR B, 0x1 gives A XOR B and 0xE gives A AND (NOT B), each with `wr_en` = 1 and the value on `result`.
- R2: Opcode 0x4 gives A + B and 0x2 gives A - B (modulo 2^32), each with `wr_en` = 1 and the value on `result`.
- R3: Opcode 0xA sets the flags from A - B and 0xB sets them from A + B; both drive `wr_en` = 0 and `result` = 0.
- R4: Opcode 0x8 sets the flags from A AND B and 0x9 from A XOR B; both drive `wr_en` = 0 and `result` = 0.
- R5: For every defined opcode, N (flags bit 3) equals bit 31 of the computed value, and Z (flags bit 2) is 1 exactly when all 32 bits of the computed value are 0.
- R6: For add-type opcodes (0x4, 0xB), C (flags bit 1) is the carry out of bit 31; for subtract-type opcodes (0x2, 0xA), C is 1 when A >= B as unsigned numbers.
- R7: For add and subtract opcodes (0x2, 0x4, 0xA, 0xB), V (flags bit 0) is 1 exactly when the operation overflows as signed two's complement.
- R8: For bitwise and test opcodes (0x0, 0x1, 0x8, 0x9, 0xC, 0xE), C takes the value of `shift_carry` and V keeps the value of `flags_in` bit 0.
- R9: Opcodes 0x3, 0x5, 0x6, 0x7, 0xD and 0xF drive `result` = 0, `wr_en` = 0 and `flags_out` equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted or immediate |
| opcode | input | 4 | Operation select |
| shift_carry | input | 1 | Carry out of the upstream shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Destination value, 0 when nothing is written |
| wr_en | output | 1 | Destination write strobe |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The checker assumes the opcode is a known value whenever it evaluates; with an unknown opcode no assertion is attempted, since no defined class exists. It also takes for granted that the operands settle in the same evaluation as the opcode, as the block holds no state. The bench therefore drives every input together, on one edge, from fully defined random words and from a fixed set of boundary words (zero, all ones, the most negative and most positive signed values), and it walks all sixteen opcodes, so the undefined codes are covered as well.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0,
    OP_EOR = 4'h1,
    OP_SUB = 4'h2,
    OP_ADD = 4'h4,
    OP_TST = 4'h8,
    OP_TEQ = 4'h9,
    OP_CMP = 4'hA,
    OP_CMN = 4'hB,
    OP_ORR = 4'hC,
    OP_BIC = 4'hE
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_ARITH = 2'd2
  } op_class_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2,
    BW_BIC = 2'd3
  } bw_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic op_class_e classify(input logic [3:0] op);
    case (op)
      OP_AND, OP_EOR, OP_ORR, OP_BIC, OP_TST, OP_TEQ: return CLS_LOGIC;
      OP_ADD, OP_SUB, OP_CMP, OP_CMN:                 return CLS_ARITH;
      default:                                        return CLS_NONE;
    endcase
  endfunction

  function automatic logic writes_dest(input logic [3:0] op);
    case (op)
      OP_AND, OP_EOR, OP_ORR, OP_BIC, OP_ADD, OP_SUB: return 1'b1;
      default:                                        return 1'b0;
    endcase
  endfunction

  function automatic logic subtracts(input logic [3:0] op);
    return (op == OP_SUB) || (op == OP_CMP);
  endfunction

  function automatic bw_sel_e bitwise_kind(input logic [3:0] op);
    case (op)
      OP_ORR:         return BW_OR;
      OP_EOR, OP_TEQ: return BW_XOR;
      OP_BIC:         return BW_BIC;
      default:        return BW_AND;
    endcase
  endfunction

endpackage

// File: rtl/alu_dp_addsub.sv
module alu_dp_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf,
  output logic             zero
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    b_eff = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    sum   = full[MSB:0];
    carry = full[WIDTH];
    ovf   = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
    zero  = ~|full[MSB:0];
  end
endmodule

// File: rtl/alu_dp_bitwise.sv
module alu_dp_bitwise
  import alu_dp_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  bw_sel_e          sel,
  output logic [WIDTH-1:0] y,
  output logic             zero
);
  always_comb begin
    case (sel)
      BW_OR:   y = a | b;
      BW_XOR:  y = a ^ b;
      BW_BIC:  y = a & ~b;
      default: y = a & b;
    endcase
    zero = ~|y;
  end
endmodule

// File: rtl/alu_dp.sv
module alu_dp
  import alu_dp_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       opcode,
  input  logic             shift_carry,
  input  logic [3:0]       flags_in,
  output logic [WIDTH-1:0] result,
  output logic             wr_en,
  output logic [3:0]       flags_out
);
  localparam int unsigned MSB = WIDTH - 1;

  op_class_e        op_cls;
  bw_sel_e          bw_kind;
  logic             do_sub;
  logic [WIDTH-1:0] arith_val;
  logic             arith_c;
  logic             arith_v;
  logic             arith_z;
  logic [WIDTH-1:0] logic_val;
  logic             logic_z;
  logic [WIDTH-1:0] alu_val;
  logic             unit_zero;
  nzcv_t            cur_flags;
  nzcv_t            nxt_flags;

  assign op_cls    = classify(opcode);
  assign bw_kind   = bitwise_kind(opcode);
  assign do_sub    = subtracts(opcode);
  assign cur_flags = nzcv_t'(flags_in);

  alu_dp_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a     (op_a),
    .b     (op_b),
    .sub   (do_sub),
    .sum   (arith_val),
    .carry (arith_c),
    .ovf   (arith_v),
    .zero  (arith_z)
  );

  alu_dp_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a    (op_a),
    .b    (op_b),
    .sel  (bw_kind),
    .y    (logic_val),
    .zero (logic_z)
  );

  always_comb begin
    alu_val   = '0;
    unit_zero = 1'b0;
    nxt_flags = cur_flags;
    case (op_cls)
      CLS_ARITH: begin
        alu_val   = arith_val;
        unit_zero = arith_z;
        nxt_flags = '{n: arith_val[MSB], z: arith_z, c: arith_c, v: arith_v};
      end
      CLS_LOGIC: begin
        alu_val   = logic_val;
        unit_zero = logic_z;
        nxt_flags = '{n: logic_val[MSB], z: logic_z, c: shift_carry,
                      v: cur_flags.v};
      end
      default: begin
        alu_val   = '0;
        unit_zero = 1'b0;
        nxt_flags = cur_flags;
      end
    endcase
  end

  assign wr_en     = writes_dest(opcode);
  assign result    = wr_en ? alu_val : '0;
  assign flags_out = nxt_flags;
endmodule

// File: rtl/alu_dp_chk.sv
module alu_dp_chk
  import alu_dp_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       opcode,
  input logic             shift_carry,
  input logic [3:0]       flags_in,
  input logic [WIDTH-1:0] result,
  input logic             wr_en,
  input logic [3:0]       flags_out,
  input op_class_e        op_cls,
  input logic [WIDTH-1:0] alu_val
);
  always_comb begin
    if (!$isunknown(opcode)) begin
      // R9
      undefined_op_chk: assert (op_cls != CLS_NONE ||
        (result == '0 && !wr_en && flags_out == flags_in));
      // R3
      compare_nowrite_chk: assert (!(opcode == 4'hA || opcode == 4'hB) ||
        (!wr_en && result == '0));
      // R4
      test_nowrite_chk: assert (!(opcode == 4'h8 || opcode == 4'h9) ||
        (!wr_en && result == '0));
      // R5
      zero_flag_chk: assert (op_cls == CLS_NONE ||
        flags_out[2] == (alu_val == '0));
      // R5
      neg_flag_chk: assert (op_cls == CLS_NONE ||
        flags_out[3] == alu_val[WIDTH-1]);
      // R8
      logic_carry_chk: assert (op_cls != CLS_LOGIC ||
        (flags_out[1] == shift_carry && flags_out[0] == flags_in[0]));
      // R2
      write_value_chk: assert (!wr_en || result == alu_val);
    end
  end

  logic unused_ops;
  assign unused_ops = ^{op_a, op_b};
endmodule

bind alu_dp alu_dp_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a        (op_a),
  .op_b        (op_b),
  .opcode      (opcode),
  .shift_carry (shift_carry),
  .flags_in    (flags_in),
  .result      (result),
  .wr_en       (wr_en),
  .flags_out   (flags_out),
  .op_cls      (op_cls),
  .alu_val     (alu_val)
);

// File: tb/alu_dp_tb.sv
module alu_dp_tb;
  logic        clk = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  opcode = 4'h3;
  logic        shift_carry = 1'b0;
  logic [3:0]  flags_in = 4'b0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  alu_dp u_dut (
    .op_a(op_a), .op_b(op_b), .opcode(opcode), .shift_carry(shift_carry),
    .flags_in(flags_in), .result(result), .wr_en(wr_en), .flags_out(flags_out)
  );

  // Reference model, written from the requirements.
  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [3:0] op, input logic sc,
                                input logic [3:0] fin, output logic [31:0] res,
                                output logic we, output logic [3:0] fl);
    logic [31:0] v;
    logic c, ov, known, arith;
    longint sa, sb, sr;
    known = 1'b1; arith = 1'b0; c = sc; ov = fin[0]; v = '0;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    case (op)
      4'h0, 4'h8: v = a & b;
      4'h1, 4'h9: v = a ^ b;
      4'hC:       v = a | b;
      4'hE:       v = a & ~b;
      4'h4, 4'hB: begin
        arith = 1'b1; v = a + b;
        c = ({32'b0, a} + {32'b0, b}) > 64'hFFFF_FFFF;
        sr = sa + sb; ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      4'h2, 4'hA: begin
        arith = 1'b1; v = a - b;
        c = (a >= b);
        sr = sa - sb; ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      default: known = 1'b0;
    endcase
    we  = (op == 4'h0 || op == 4'h1 || op == 4'h2 || op == 4'h4 ||
           op == 4'hC || op == 4'hE);
    res = we ? v : 32'h0;
    fl  = known ? {v[31], (v == 32'h0), c, ov} : fin;
    if (arith) begin end
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'hC, 4'hE: return "R1";
      4'h2, 4'h4:             return "R2";
      4'hA, 4'hB:             return "R3";
      4'h8, 4'h9:             return "R4";
      default:                return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (op %h a %h b %h)",
               req, what, act, exp, opcode, op_a, op_b);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] op, input logic sc,
                       input logic [3:0] fin);
    logic [31:0] er; logic ew; logic [3:0] ef;
    @(posedge clk);
    op_a = a; op_b = b; opcode = op; shift_carry = sc; flags_in = fin;
    @(negedge clk);
    model(a, b, op, sc, fin, er, ew, ef);
    check(tag_of(op), "result", result, er);
    check(tag_of(op), "wr_en", {31'b0, wr_en}, {31'b0, ew});
    // R5 R6 R7 R8 R9 flags
    if (tag_of(op) == "R9")
      check("R9", "flags", {28'b0, flags_out}, {28'b0, ef});
    else begin
      check("R5", "flags N/Z", {30'b0, flags_out[3:2]}, {30'b0, ef[3:2]});
      if (op == 4'h2 || op == 4'h4 || op == 4'hA || op == 4'hB) begin
        check("R6", "flag C", {31'b0, flags_out[1]}, {31'b0, ef[1]});
        check("R7", "flag V", {31'b0, flags_out[0]}, {31'b0, ef[0]});
      end else
        check("R8", "flags C/V", {30'b0, flags_out[1:0]}, {30'b0, ef[1:0]});
    end
  endtask

  initial begin
    logic [31:0] corner [6];
    int unsigned seed_init;
    corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h0000_0001; corner[5] = 32'h5555_AAAA;
    seed_init = $urandom(32'd1234);
    @(negedge clk);
    // Initial state with an undefined opcode (R9)
    check("R9", "initial result", result, 32'h0);
    check("R9", "initial wr_en", {31'b0, wr_en}, 32'h0);
    check("R9", "initial flags", {28'b0, flags_out}, {28'b0, flags_in});
    // Directed corners over all opcodes and all flag patterns
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(corner[i], corner[j], 4'(op), 1'((i + j) & 1), 4'(op + i));
    // Specific boundary cases
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'h4, 1'b0, 4'h0); // R7 add ovf
    apply(32'h8000_0000, 32'h0000_0001, 4'h2, 1'b0, 4'h0); // R7 sub ovf
    apply(32'h0000_0005, 32'h0000_0005, 4'hA, 1'b0, 4'h0); // R6 equal no borrow
    apply(32'h0000_0004, 32'h0000_0005, 4'hA, 1'b1, 4'hF); // R6 borrow
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 4'hE, 1'b1, 4'h1); // R1 bit clear
    apply(32'h1234_5678, 32'h1234_5678, 4'h9, 1'b0, 4'h1); // R4 equal TEQ
    // Random vectors
    for (int k = 0; k < 4000; k++)
      apply($urandom, $urandom, 4'($urandom), 1'($urandom), 4'($urandom));
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule